// File: doc/BRIEF.md
# Scratchpad Write and Copy Controller

This block sits between an already-decoded serial byte link and a 512-byte paged memory (16 pages of 32 bytes). All memory updates go through a 32-byte staging buffer. A host first writes the buffer with a 16-bit target address and data. It can then read back the address registers, a status byte and the staged data. Finally it commits the staged bytes to memory by echoing the two address bytes and the status byte exactly as stored.

The status byte combines four things. Bits 4:0 hold the offset of the last byte written into the buffer. Bit 5 is an invalid flag, set on a partial or empty write and on power loss. Bit 6 always reads 0. Bit 7 is a committed flag that marks a finished copy. The host can only read this byte. A frame opens with a pulse on `frm_start`, and the next complete byte is the command code. Every byte of the frame arrives as a one-cycle strobe. A pulse on `frm_end` closes the frame and says whether trailing bits were left over.

Top module: `scratch_copy_ctrl`

## Requirements
- R1: After reset a readback returns address bytes 00h, 00h and status 20h (invalid flag set, committed flag clear, last offset 0), and `busy` is low.
- R2: Command 0Fh is followed by the low address byte and then the high address byte. Data bytes are then stored from the offset given by the low 5 address bits upward. Status bits 4:0 take the offset of each byte as it is stored.
- R3: Once offset 1Fh has been written, further data bytes in the frame are ignored and leave the status offset at 1Fh.
- R4: A write frame that ends with leftover bits (`frm_partial`=1), or that ends without any data byte, sets status bit 5. A write frame that ends cleanly after at least one data byte clears it.
- R5: A `pwr_loss` pulse sets status bit 5 in the following cycle.
- R6: Status bit 6 always reads 0.
- R7: Command 0Fh clears status bit 7. A completed copy sets it.
- R8: Command AAh opens a readback. Each `tx_req` produces one byte on `tx_data`, with `tx_vld` high, in the next cycle. The bytes come in this order: low address, high address, status, then buffer bytes from the start offset through the last offset, then FFh.
- R9: Command 55h is followed by three authorization bytes. If any of them differs from the stored low address, high address or status byte, memory and status bit 7 stay unchanged.
- R10: A copy requested while status bit 5 is set writes nothing and leaves status bit 7 clear.
- R11: An accepted copy raises `busy` in the cycle after the third authorization byte. It then writes one byte per cycle, from the start offset through the last offset, to memory address {target[8:5], offset}, and `busy` stays high for exactly that many cycles.
- R12: A frame whose command code is none of 0Fh, AAh or 55h changes neither the address registers nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Opens a frame; the next byte is the command code |
| frm_end | input | 1 | Closes the current frame |
| frm_partial | input | 1 | With `frm_end`: bits left over that do not form a byte |
| rx_vld | input | 1 | Strobe for a complete received byte |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Requests the next readback byte |
| tx_vld | output | 1 | Readback byte valid |
| tx_data | output | 8 | Readback byte |
| pwr_loss | input | 1 | Invalidates the staged data |
| busy | output | 1 | Copy in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 9 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A received byte changes the address and status registers at the clock edge that samples it. So a readback issued any later sees the new value, and the bench reads status only through the readback path. A readback byte appears one edge after its `tx_req`, so the bench samples it at the falling edge that follows. A copy raises `busy` one edge after the third authorization byte and lands its last memory write on the edge that drops `busy`. The bench therefore counts busy cycles at falling edges and inspects its memory model only after `busy` falls.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_CMD,
    ST_WTA1,
    ST_WTA2,
    ST_WDAT,
    ST_RD,
    ST_AUTH,
    ST_COPY
  } scp_state_t;
endpackage

// File: rtl/scp_buffer.sv
module scp_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && (addr == AW'(i))) begin
        mem_q[i] <= wdata;
      end
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/scp_regs.sv
module scp_regs #(
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_ta1,
  input  logic             ld_ta2,
  input  logic [7:0]       din,
  input  logic             ld_end,
  input  logic [OFS_W-1:0] end_in,
  input  logic             pf_set,
  input  logic             pf_clr,
  input  logic             aa_set,
  input  logic             aa_clr,
  output logic [7:0]       ta1,
  output logic [7:0]       ta2,
  output logic [7:0]       es
);
  logic [7:0]       ta1_q, ta2_q;
  logic [OFS_W-1:0] end_q;
  logic             pf_q, pf_d, pf_en;
  logic             aa_q, aa_d, aa_en;

  // invalid flag: a set request wins over a clear request
  always_comb begin
    pf_en = pf_set | pf_clr;
    pf_d  = pf_set;
    aa_en = aa_set | aa_clr;
    aa_d  = aa_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta1_q <= '0;
      ta2_q <= '0;
      end_q <= '0;
      pf_q  <= 1'b1;
      aa_q  <= 1'b0;
    end else begin
      if (ld_ta1) ta1_q <= din;
      if (ld_ta2) ta2_q <= din;
      if (ld_end) end_q <= end_in;
      if (pf_en)  pf_q  <= pf_d;
      if (aa_en)  aa_q  <= aa_d;
    end
  end

  assign ta1 = ta1_q;
  assign ta2 = ta2_q;
  assign es  = {aa_q, 1'b0, pf_q, 5'(end_q)};
endmodule

// File: rtl/scp_fsm.sv
module scp_fsm
  import scp_pkg::*;
#(
  parameter int         OFS_W    = 5,
  parameter int         MEM_AW   = 9,
  parameter logic [7:0] OP_WRITE = 8'h0F,
  parameter logic [7:0] OP_READ  = 8'hAA,
  parameter logic [7:0] OP_COPY  = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              frm_partial,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  input  logic              tx_req,
  input  logic [7:0]        ta1,
  input  logic [7:0]        ta2,
  input  logic [7:0]        es,
  input  logic [7:0]        buf_rdata,
  output logic [OFS_W-1:0]  ptr,
  output logic              buf_we,
  output logic              ld_ta1,
  output logic              ld_ta2,
  output logic              ld_end,
  output logic              pf_set,
  output logic              pf_clr,
  output logic              aa_set,
  output logic              aa_clr,
  output logic              tx_vld,
  output logic [7:0]        tx_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              busy,
  output scp_state_t        state
);
  localparam logic [OFS_W-1:0] LAST = '1;

  scp_state_t       st_q, st_d;
  logic [OFS_W-1:0] ptr_q, ptr_d;
  logic [1:0]       ph_q, ph_d;
  logic             got_q, got_d, full_q, full_d, ok_q, ok_d, done_q, done_d;
  logic             txv_q, txv_d;
  logic [7:0]       txd_q, txd_d;
  logic [7:0]       auth_ref;
  logic [15:0]      ta_full;
  logic [OFS_W-1:0] start_ofs, end_ofs;
  logic             in_write;

  assign ta_full   = {ta2, ta1};
  assign start_ofs = ta1[OFS_W-1:0];
  assign end_ofs   = es[OFS_W-1:0];
  assign in_write  = (st_q == ST_WTA1) || (st_q == ST_WTA2) || (st_q == ST_WDAT);

  always_comb begin
    case (ph_q)
      2'd0:    auth_ref = ta1;
      2'd1:    auth_ref = ta2;
      default: auth_ref = es;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    ph_d   = ph_q;
    got_d  = got_q;
    full_d = full_q;
    ok_d   = ok_q;
    done_d = done_q;
    txv_d  = 1'b0;
    txd_d  = txd_q;
    buf_we = 1'b0;
    ld_ta1 = 1'b0;
    ld_ta2 = 1'b0;
    ld_end = 1'b0;
    pf_set = 1'b0;
    pf_clr = 1'b0;
    aa_set = 1'b0;
    aa_clr = 1'b0;
    mem_we = 1'b0;
    if (st_q == ST_COPY) begin
      mem_we = 1'b1;
      if (ptr_q == end_ofs) begin
        aa_set = 1'b1;
        st_d   = ST_OFF;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (frm_start) begin
      st_d = ST_CMD;
    end else if (frm_end) begin
      if (in_write) begin
        if (frm_partial || !got_q) pf_set = 1'b1;
        else                       pf_clr = 1'b1;
      end
      st_d = ST_OFF;
    end else if (rx_vld) begin
      case (st_q)
        ST_CMD: begin
          if (rx_data == OP_WRITE) begin
            aa_clr = 1'b1;
            pf_set = 1'b1;
            got_d  = 1'b0;
            st_d   = ST_WTA1;
          end else if (rx_data == OP_READ) begin
            ph_d   = 2'd0;
            ptr_d  = start_ofs;
            done_d = 1'b0;
            st_d   = ST_RD;
          end else if (rx_data == OP_COPY) begin
            ph_d = 2'd0;
            ok_d = 1'b1;
            st_d = ST_AUTH;
          end else begin
            st_d = ST_OFF;
          end
        end
        ST_WTA1: begin
          ld_ta1 = 1'b1;
          st_d   = ST_WTA2;
        end
        ST_WTA2: begin
          ld_ta2 = 1'b1;
          ptr_d  = start_ofs;
          full_d = 1'b0;
          st_d   = ST_WDAT;
        end
        ST_WDAT: begin
          if (!full_q) begin
            buf_we = 1'b1;
            ld_end = 1'b1;
            got_d  = 1'b1;
            if (ptr_q == LAST) full_d = 1'b1;
            else               ptr_d  = ptr_q + 1'b1;
          end
        end
        ST_AUTH: begin
          if (ph_q == 2'd2) begin
            if (ok_q && (rx_data == auth_ref) && !es[5]) begin
              ptr_d = start_ofs;
              st_d  = ST_COPY;
            end else begin
              st_d = ST_OFF;
            end
          end else begin
            ok_d = ok_q && (rx_data == auth_ref);
            ph_d = ph_q + 2'd1;
          end
        end
        default: ;
      endcase
    end else if (tx_req && (st_q == ST_RD)) begin
      txv_d = 1'b1;
      case (ph_q)
        2'd0: txd_d = ta1;
        2'd1: txd_d = ta2;
        2'd2: txd_d = es;
        default: begin
          if (done_q) begin
            txd_d = 8'hFF;
          end else begin
            txd_d = buf_rdata;
            if (ptr_q == end_ofs) done_d = 1'b1;
            else                  ptr_d  = ptr_q + 1'b1;
          end
        end
      endcase
      if (ph_q != 2'd3) ph_d = ph_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ptr_q  <= '0;
      ph_q   <= '0;
      got_q  <= 1'b0;
      full_q <= 1'b0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
      txv_q  <= 1'b0;
      txd_q  <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      ph_q   <= ph_d;
      got_q  <= got_d;
      full_q <= full_d;
      ok_q   <= ok_d;
      done_q <= done_d;
      txv_q  <= txv_d;
      txd_q  <= txd_d;
    end
  end

  assign ptr      = ptr_q;
  assign tx_vld   = txv_q;
  assign tx_data  = txd_q;
  assign mem_addr = {ta_full[MEM_AW-1:OFS_W], ptr_q};
  assign busy     = (st_q == ST_COPY);
  assign state    = st_q;
endmodule

// File: rtl/scratch_copy_ctrl.sv
module scratch_copy_ctrl
  import scp_pkg::*;
#(
  parameter int         PAGE_BYTES = 32,
  parameter int         PAGES      = 16,
  parameter logic [7:0] OP_WRITE   = 8'h0F,
  parameter logic [7:0] OP_READ    = 8'hAA,
  parameter logic [7:0] OP_COPY    = 8'h55,
  localparam int        OFS_W      = $clog2(PAGE_BYTES),
  localparam int        MEM_AW     = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              frm_partial,
  input  logic              rx_vld,
  input  logic [7:0]        rx_data,
  input  logic              tx_req,
  output logic              tx_vld,
  output logic [7:0]        tx_data,
  input  logic              pwr_loss,
  output logic              busy,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic [OFS_W-1:0] ptr;
  logic             buf_we, ld_ta1, ld_ta2, ld_end;
  logic             pf_set_fsm, pf_clr, aa_set, aa_clr;
  logic [7:0]       ta1, ta2, es, buf_rdata;
  scp_state_t       fsm_state;

  scp_buffer #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .addr  (ptr),
    .wdata (rx_data),
    .rdata (buf_rdata)
  );

  scp_regs #(.OFS_W(OFS_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_ta1 (ld_ta1),
    .ld_ta2 (ld_ta2),
    .din    (rx_data),
    .ld_end (ld_end),
    .end_in (ptr),
    .pf_set (pf_set_fsm | pwr_loss),
    .pf_clr (pf_clr),
    .aa_set (aa_set),
    .aa_clr (aa_clr),
    .ta1    (ta1),
    .ta2    (ta2),
    .es     (es)
  );

  scp_fsm #(
    .OFS_W(OFS_W), .MEM_AW(MEM_AW),
    .OP_WRITE(OP_WRITE), .OP_READ(OP_READ), .OP_COPY(OP_COPY)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_start   (frm_start),
    .frm_end     (frm_end),
    .frm_partial (frm_partial),
    .rx_vld      (rx_vld),
    .rx_data     (rx_data),
    .tx_req      (tx_req),
    .ta1         (ta1),
    .ta2         (ta2),
    .es          (es),
    .buf_rdata   (buf_rdata),
    .ptr         (ptr),
    .buf_we      (buf_we),
    .ld_ta1      (ld_ta1),
    .ld_ta2      (ld_ta2),
    .ld_end      (ld_end),
    .pf_set      (pf_set_fsm),
    .pf_clr      (pf_clr),
    .aa_set      (aa_set),
    .aa_clr      (aa_clr),
    .tx_vld      (tx_vld),
    .tx_data     (tx_data),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .state       (fsm_state)
  );

  assign mem_wdata = buf_rdata;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
#(
  parameter int         OFS_W    = 5,
  parameter int         MEM_AW   = 9,
  parameter logic [7:0] OP_WRITE = 8'h0F
) (
  input logic              clk,
  input logic              rst_n,
  input scp_state_t        st,
  input logic              frm_start,
  input logic              frm_end,
  input logic              rx_vld,
  input logic [7:0]        rx_data,
  input logic              pwr_loss,
  input logic              busy,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [7:0]        es
);
  AST_AA_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && rx_vld && rx_data == OP_WRITE && !frm_start && !frm_end) |=> !es[7]); // R7
  AST_PF_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_loss |=> es[5]); // R5
  AST_COPY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!es[5])); // R10
  AST_AA_ONLY_FROM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es[7]) |-> $past(busy)); // R9
  AST_WE_WITHIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[OFS_W-1:0] <= es[OFS_W-1:0])); // R11
  AST_END_MOVES_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(es[4:0]) |-> $past(st == ST_WDAT && rx_vld)); // R2
endmodule

bind scratch_copy_ctrl scp_checker #(
  .OFS_W(OFS_W), .MEM_AW(MEM_AW), .OP_WRITE(OP_WRITE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (fsm_state),
  .frm_start (frm_start),
  .frm_end   (frm_end),
  .rx_vld    (rx_vld),
  .rx_data   (rx_data),
  .pwr_loss  (pwr_loss),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .es        (es)
);

// File: tb/tb_scratch_copy_ctrl.sv
module tb_scratch_copy_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       frm_start, frm_end, frm_partial, rx_vld, tx_req, pwr_loss;
  logic [7:0] rx_data;
  logic       tx_vld, busy, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem [512];
  int tests, fails;

  scratch_copy_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .frm_partial(frm_partial), .rx_vld(rx_vld), .rx_data(rx_data),
    .tx_req(tx_req), .tx_vld(tx_vld), .tx_data(tx_data_w), .pwr_loss(pwr_loss),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
  logic [7:0] tx_data_w;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'h00;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 13);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fstart();
    frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
  endtask
  task automatic fend(input logic part);
    frm_end = 1'b1; frm_partial = part; @(negedge clk); frm_end = 1'b0; frm_partial = 1'b0;
  endtask
  task automatic sbyte(input logic [7:0] b);
    rx_vld = 1'b1; rx_data = b; @(negedge clk); rx_vld = 1'b0;
  endtask
  task automatic rbyte(output logic [7:0] b);
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
    chk("R8 tx_vld", 32'(tx_vld), 1);
    b = tx_data_w;
  endtask

  task automatic write_sp(input logic [15:0] ta, input int n, input logic [7:0] seed,
                          input logic part);
    fstart(); sbyte(8'h0F); sbyte(ta[7:0]); sbyte(ta[15:8]);
    for (int k = 0; k < n; k++) sbyte(pat(seed, k));
    fend(part);
  endtask

  task automatic read_hdr(input string tag, input logic [7:0] e1, input logic [7:0] e2,
                          input logic [7:0] ee);
    logic [7:0] b;
    fstart(); sbyte(8'hAA);
    rbyte(b); chk({tag, " TA1"}, 32'(b), 32'(e1));
    rbyte(b); chk({tag, " TA2"}, 32'(b), 32'(e2));
    rbyte(b); chk({tag, " ES"}, 32'(b), 32'(ee));
    chk("R6 bit6", 32'(b[6]), 0);
  endtask

  task automatic copy_sp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         output int cyc);
    fstart(); sbyte(8'h55); sbyte(a); sbyte(b); sbyte(c);
    cyc = 0;
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    fend(1'b0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    read_hdr("R1", 8'h00, 8'h00, 8'h20);
    fend(1'b0);
  endtask

  task automatic t_full_page();
    logic [7:0] b;
    write_sp(16'h0140, 32, 8'h5A, 1'b0);
    read_hdr("R2 R4", 8'h40, 8'h01, 8'h1F);
    for (int k = 0; k < 32; k++) begin
      rbyte(b); chk("R8 data", 32'(b), 32'(pat(8'h5A, k)));
    end
    rbyte(b); chk("R8 tail", 32'(b), 32'hFF);
    fend(1'b0);
  endtask

  task automatic t_copy_ok();
    int cyc;
    copy_sp(8'h40, 8'h01, 8'h1F, cyc);
    chk("R11 busy cycles", 32'(cyc), 32);
    for (int k = 0; k < 32; k++) chk("R11 mem", 32'(mem[9'h140 + k]), 32'(pat(8'h5A, k)));
    chk("R11 next page", 32'(mem[9'h160]), 0);
    read_hdr("R7 set", 8'h40, 8'h01, 8'h9F);
    fend(1'b0);
  endtask

  task automatic t_offset_full();
    logic [7:0] b;
    write_sp(16'h003C, 6, 8'hC3, 1'b0);
    read_hdr("R3 R7 clr", 8'h3C, 8'h00, 8'h1F);
    for (int k = 0; k < 4; k++) begin
      rbyte(b); chk("R3 data", 32'(b), 32'(pat(8'hC3, k)));
    end
    rbyte(b); chk("R3 R8 tail", 32'(b), 32'hFF);
    fend(1'b0);
  endtask

  task automatic t_copy_bad();
    int cyc;
    copy_sp(8'h3C, 8'h00, 8'h1E, cyc);
    chk("R9 no busy", 32'(cyc), 0);
    chk("R9 mem", 32'(mem[9'h03C]), 0);
    read_hdr("R9 aa", 8'h3C, 8'h00, 8'h1F);
    fend(1'b0);
    copy_sp(8'h3D, 8'h00, 8'h1F, cyc);
    chk("R9 ta1 mismatch", 32'(cyc), 0);
  endtask

  task automatic t_copy_small();
    int cyc;
    copy_sp(8'h3C, 8'h00, 8'h1F, cyc);
    chk("R11 small cycles", 32'(cyc), 4);
    for (int k = 0; k < 4; k++) chk("R11 small mem", 32'(mem[9'h03C + k]), 32'(pat(8'hC3, k)));
    chk("R11 below start", 32'(mem[9'h03B]), 0);
  endtask

  task automatic t_partial();
    int cyc;
    write_sp(16'h0005, 2, 8'h11, 1'b1);
    read_hdr("R4 partial", 8'h05, 8'h00, 8'h26);
    fend(1'b0);
    copy_sp(8'h05, 8'h00, 8'h26, cyc);
    chk("R10 no copy", 32'(cyc), 0);
    chk("R10 mem", 32'(mem[9'h005]), 0);
    read_hdr("R10 aa", 8'h05, 8'h00, 8'h26);
    fend(1'b0);
  endtask

  task automatic t_nodata();
    write_sp(16'h0010, 0, 8'h00, 1'b0);
    read_hdr("R4 empty", 8'h10, 8'h00, 8'h26);
    fend(1'b0);
  endtask

  task automatic t_pwr();
    int cyc;
    write_sp(16'h01E0, 1, 8'h77, 1'b0);
    read_hdr("R4 clean", 8'hE0, 8'h01, 8'h00);
    fend(1'b0);
    pwr_loss = 1'b1; @(negedge clk); pwr_loss = 1'b0;
    read_hdr("R5", 8'hE0, 8'h01, 8'h20);
    fend(1'b0);
    copy_sp(8'hE0, 8'h01, 8'h20, cyc);
    chk("R10 after loss", 32'(cyc), 0);
    chk("R10 mem after loss", 32'(mem[9'h1E0]), 0);
  endtask

  task automatic t_bad_op();
    fstart(); sbyte(8'h33); sbyte(8'h12); sbyte(8'h34); sbyte(8'h56); fend(1'b1);
    read_hdr("R12", 8'hE0, 8'h01, 8'h20);
    fend(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; frm_start = 0; frm_end = 0; frm_partial = 0;
    rx_vld = 0; rx_data = 0; tx_req = 0; pwr_loss = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_page();
    t_copy_ok();
    t_offset_full();
    t_copy_bad();
    t_copy_small();
    t_partial();
    t_nodata();
    t_pwr();
    t_bad_op();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule